// File: doc/BRIEF.md
# Serial Line Encoder with Transition Stuffing

This block turns a stream of bytes into a single serial line level for a low-speed differential bus. Each byte is accepted on a valid/ready handshake and shifted out least significant bit first. Before coding, a 0 is inserted into the bit stream whenever six 1s have gone out in a row. The result is then line-coded so that a 0 flips the line level and a 1 keeps it. With this coding the receiver always sees a transition within seven bit times and can recover the clock from the line.

Bits leave at a rate set by an internal enable divider. A mode input chooses between a slow rate and a fast rate that is eight times higher. The line level, its complement for the second wire of the pair, and a strobe that marks each bit boundary are all registered. When no byte is waiting at a bit boundary, the line returns to its high resting level and the run of 1s is forgotten. The next stream is then coded relative to that high level.

Top module: `serline_tx`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `line_p`=1, `line_n`=0, `line_stb`=0 and `in_ready`=1.
- R2: A data bit of 0 sent at a bit boundary inverts `line_p`; a data bit of 1 leaves it unchanged.
- R3: Bit 0 of each accepted byte is sent first and bit 7 last.
- R4: After six consecutive 1s have been sent, the next symbol is an inserted 0 that inverts the line. It is not taken from the byte. So seven unchanged data symbols in a row never occur inside a stream.
- R5: The count of consecutive 1s is carried from one byte into the next byte of a stream. Any 0 clears it, an inserted 0 included.
- R6: `in_ready` is 1 only when no bit of the current byte remains to be sent and no inserted 0 is pending.
- R7: `line_n` is the complement of `line_p` in every cycle.
- R8: `line_stb` pulses once every `DIV_SLOW` clock cycles when `fast_mode`=0 and once every `DIV_FAST` cycles when `fast_mode`=1 (defaults 32 and 4).
- R9: At a bit boundary with no bit and no inserted 0 pending, `line_p` goes to 1 and the run count is cleared. The first bit of the next byte is coded relative to that level.
- R10: `line_p` changes only in cycles in which `line_stb` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fast_mode | input | 1 | 1 selects the fast bit rate, 0 the slow one |
| in_valid | input | 1 | A byte is offered on in_data |
| in_ready | output | 1 | The block takes the offered byte at this edge |
| in_data | input | W | Byte to send, LSB first |
| line_p | output | 1 | Coded line level, rests high |
| line_n | output | 1 | Complement of line_p |
| line_stb | output | 1 | One-cycle pulse in the cycle the line takes a new bit |

## Verification
Streams of all-ones bytes show whether insertion triggers after exactly six 1s and whether the run carries across a byte boundary. Bytes of all zeros show toggling on every bit. A byte whose six low bits are 1 separates an inserted 0 from the byte's own following 0. Random bytes, heavy in 0xFF, are sent at both rates with idle gaps between streams, so the line is seen returning high and the next stream starting from it. A decoder in the bench removes the inserted 0s and rebuilds the sent bits. It flags any run of seven 1s.

// File: rtl/serline_pkg.sv
package serline_pkg;
  // Kind of symbol the stuffer hands to the line coder at a bit boundary
  typedef enum logic [1:0] {
    SYM_IDLE  = 2'd0,
    SYM_DATA  = 2'd1,
    SYM_STUFF = 2'd2
  } sym_e;
endpackage

// File: rtl/serline_tick.sv
module serline_tick #(
  parameter int DIV_SLOW = 32,
  parameter int DIV_FAST = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fast_mode,
  output logic tick
);
  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int CW      = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
  localparam logic [CW-1:0] LAST_SLOW = CW'(DIV_SLOW - 1);
  localparam logic [CW-1:0] LAST_FAST = CW'(DIV_FAST - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;
  logic          wrap;

  assign last = fast_mode ? LAST_FAST : LAST_SLOW;
  assign wrap = (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      tick  <= wrap;
    end
  end
endmodule

// File: rtl/serline_stuff.sv
module serline_stuff
  import serline_pkg::*;
#(
  parameter int W   = 8,
  parameter int RUN = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [W-1:0]                 in_data,
  output sym_e                         sym_kind,
  output logic                         sym_bit,
  output logic [$clog2(RUN+1)-1:0]     run_o
);
  localparam int LW = $clog2(W + 1);
  localparam int RW = $clog2(RUN + 1);
  localparam logic [LW-1:0] W_V   = LW'(W);
  localparam logic [RW-1:0] RUN_V = RW'(RUN);

  logic [W-1:0]  sh_q;
  logic [LW-1:0] left_q;
  logic [RW-1:0] ones_q;

  // Pending insertion wins over the byte; an empty shifter means idle
  always_comb begin
    if (ones_q == RUN_V) begin
      sym_kind = SYM_STUFF;
      sym_bit  = 1'b0;
    end else if (left_q != '0) begin
      sym_kind = SYM_DATA;
      sym_bit  = sh_q[0];
    end else begin
      sym_kind = SYM_IDLE;
      sym_bit  = 1'b1;
    end
  end

  assign in_ready = (left_q == '0) && (ones_q != RUN_V);
  assign run_o    = ones_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      left_q <= '0;
      ones_q <= '0;
    end else begin
      if (tick) begin
        unique case (sym_kind)
          SYM_STUFF: ones_q <= '0;
          SYM_DATA: begin
            sh_q   <= sh_q >> 1;
            left_q <= left_q - 1'b1;
            ones_q <= sym_bit ? ones_q + 1'b1 : '0;
          end
          default:   ones_q <= '0;
        endcase
      end
      // A load only happens with the shifter empty, so it never meets a DATA step
      if (in_valid && in_ready) begin
        sh_q   <= in_data;
        left_q <= W_V;
      end
    end
  end
endmodule

// File: rtl/serline_nrzi.sv
module serline_nrzi
  import serline_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  sym_e sym_kind,
  input  logic sym_bit,
  output logic line_p,
  output logic line_n,
  output logic line_stb
);
  // Two separate flops for the pair so each wire has its own driver register
  always_ff @(posedge clk) begin
    if (rst) begin
      line_p   <= 1'b1;
      line_n   <= 1'b0;
      line_stb <= 1'b0;
    end else begin
      line_stb <= tick;
      if (tick) begin
        if (sym_kind == SYM_IDLE) begin
          line_p <= 1'b1;
          line_n <= 1'b0;
        end else if (!sym_bit) begin
          line_p <= ~line_p;
          line_n <= line_p;
        end
      end
    end
  end
endmodule

// File: rtl/serline_tx.sv
module serline_tx
  import serline_pkg::*;
#(
  parameter int W        = 8,
  parameter int RUN      = 6,
  parameter int DIV_SLOW = 32,
  parameter int DIV_FAST = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fast_mode,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         line_p,
  output logic         line_n,
  output logic         line_stb
);
  localparam int RW = $clog2(RUN + 1);

  logic          tick;
  sym_e          sym_kind;
  logic          sym_bit;
  logic [RW-1:0] run_cnt;

  serline_tick #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_tick (
    .clk       (clk),
    .rst       (rst),
    .fast_mode (fast_mode),
    .tick      (tick)
  );

  serline_stuff #(.W(W), .RUN(RUN)) u_stuff (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .sym_kind (sym_kind),
    .sym_bit  (sym_bit),
    .run_o    (run_cnt)
  );

  serline_nrzi u_nrzi (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .sym_kind (sym_kind),
    .sym_bit  (sym_bit),
    .line_p   (line_p),
    .line_n   (line_n),
    .line_stb (line_stb)
  );
endmodule

// File: rtl/serline_tx_chk.sv
module serline_tx_chk #(
  parameter int RUN      = 6,
  parameter int DIV_SLOW = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     line_p,
  input logic                     line_n,
  input logic                     line_stb,
  input logic [$clog2(RUN+1)-1:0] run_cnt
);
  localparam int GW = $clog2(DIV_SLOW + 4) + 1;
  localparam logic [GW-1:0] GAP_MAX = GW'(DIV_SLOW + 2);

  logic [GW-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst)                gap_q <= '0;
    else if (line_stb)      gap_q <= '0;
    else if (gap_q != '1)   gap_q <= gap_q + 1'b1;
  end

  AST_PAIR_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    line_n == ~line_p); // R7

  AST_LINE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !line_stb |-> $stable(line_p)); // R10

  AST_STUFF_FLIPS: assert property (@(posedge clk) disable iff (rst)
    (line_stb && ($past(run_cnt) == ($clog2(RUN+1))'(RUN))) |-> (line_p != $past(line_p))); // R4

  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (rst)
    gap_q <= GAP_MAX); // R8
endmodule

bind serline_tx serline_tx_chk #(.RUN(RUN), .DIV_SLOW(DIV_SLOW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .line_p   (line_p),
  .line_n   (line_n),
  .line_stb (line_stb),
  .run_cnt  (run_cnt)
);

// File: tb/serline_tx_test.sv
module serline_tx_test;
  localparam int W        = 8;
  localparam int DIV_SLOW = 32;
  localparam int DIV_FAST = 4;
  localparam int WD_LIMIT = 190000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         fast_mode = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ready, line_p, line_n, line_stb;

  serline_tx #(.W(W), .RUN(6), .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) uut (
    .clk(clk), .rst(rst), .fast_mode(fast_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .line_p(line_p),
    .line_n(line_n), .line_stb(line_stb)
  );

  always #10 clk = ~clk;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- model of the expected line ----------------
  bit  mq[$];        // data bits still to send
  bit  sent_all[$];  // every data bit accepted
  bit  dec_bits[$];  // bits rebuilt by the bench decoder
  int  mones = 0;
  bit  mline = 1'b1;
  bit  prev_line = 1'b1;
  int  cyc = 0, last_stb_cyc = 0, skip = 2;
  bit  have_stb = 0;
  bit  last_fast = 0;
  bit  dec_prev = 1'b1;
  int  dec_run = 0, dec_err = 0;

  function automatic bit expect_level(input bit cur, input bit b);
    return b ? cur : ~cur;   // 0 flips, 1 holds
  endfunction

  task automatic decode(input bit lvl);
    bit raw;
    raw = (lvl == dec_prev);
    dec_prev = lvl;
    if (dec_run == 6) begin
      if (raw) dec_err++;
      dec_run = 0;
    end else begin
      dec_bits.push_back(raw);
      dec_run = raw ? dec_run + 1 : 0;
    end
  endtask

  always @(negedge clk) begin
    #1;
    cyc++;
    if (!rst && !finished) begin
      if (fast_mode != last_fast) begin
        skip = 2;
        last_fast = fast_mode;
      end
      if (!line_stb) begin
        chk(line_p == prev_line, "R10 line moved without strobe", line_p, prev_line);
      end else begin
        if (have_stb && skip == 0)
          chk((cyc - last_stb_cyc) == (fast_mode ? DIV_FAST : DIV_SLOW),
              "R8 strobe spacing", cyc - last_stb_cyc, fast_mode ? DIV_FAST : DIV_SLOW);
        if (skip > 0) skip--;
        have_stb = 1;
        last_stb_cyc = cyc;
        if (mones == 6) begin
          mline = ~mline;
          mones = 0;
          chk(line_p == mline, "R4 inserted zero", line_p, mline);
          decode(line_p);
        end else if (mq.size() != 0) begin
          bit b;
          b = mq.pop_front();
          mline = expect_level(mline, b);
          mones = b ? mones + 1 : 0;
          chk(line_p == mline, "R2/R3/R5 data symbol", line_p, mline);
          decode(line_p);
        end else begin
          mline = 1'b1;
          mones = 0;
          dec_prev = 1'b1;
          dec_run = 0;
          chk(line_p == 1'b1, "R9 idle level", line_p, 1);
        end
        chk(line_n == ~line_p, "R7 complement", line_n, ~line_p);
        chk(in_ready == (mq.size() == 0 && mones != 6), "R6 ready",
            in_ready, (mq.size() == 0 && mones != 6));
      end
      if (in_valid && in_ready) begin
        for (int i = 0; i < W; i++) begin
          mq.push_back(in_data[i]);
          sent_all.push_back(in_data[i]);
        end
      end
    end
    prev_line = line_p;
  end

  // ---------------- stimulus ----------------
  task automatic send_byte(input logic [W-1:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (!in_ready || mq.size() != 0) @(negedge clk);
    repeat (3 * DIV_SLOW) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", WD_LIMIT, 0);
    finish_run();
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd7321);
    repeat (3) @(negedge clk);
    chk(line_p == 1'b1 && line_n == 1'b0, "R1 reset line", {line_p, line_n}, 2);
    chk(line_stb == 1'b0, "R1 reset strobe", line_stb, 0);
    chk(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(line_p == 1'b1 && line_stb == 1'b0 && in_ready == 1'b1,
        "R1 after release", {line_p, line_stb, in_ready}, 5);

    // Directed, slow rate: run carried over a byte boundary, then all zeros
    send_byte(8'hFF); send_byte(8'hFF); send_byte(8'h00);
    drain();
    // Six low ones followed by real zeros; then restart from idle
    send_byte(8'h3F);
    drain();
    send_byte(8'h00);
    drain();
    // Directed, fast rate
    fast_mode = 1'b1;
    repeat (8) @(negedge clk);
    send_byte(8'h7E); send_byte(8'hFF); send_byte(8'hFF);
    send_byte(8'hFF); send_byte(8'h01);
    drain();

    // Random streams at random rates
    for (int s = 0; s < 30; s++) begin
      int nb;
      fast_mode = ($urandom % 3) != 0;
      repeat (8) @(negedge clk);
      nb = 1 + ($urandom % 6);
      for (int k = 0; k < nb; k++) begin
        logic [W-1:0] b;
        b = (($urandom % 3) == 0) ? 8'hFF : W'($urandom);
        send_byte(b);
      end
      drain();
    end

    // Decoder cross-check of the whole transfer
    chk(dec_err == 0, "R4 seven-ones run seen by decoder", dec_err, 0);
    chk(dec_bits.size() == sent_all.size(), "R3 decoded bit count",
        dec_bits.size(), sent_all.size());
    begin
      int mism;
      mism = 0;
      for (int i = 0; i < dec_bits.size() && i < sent_all.size(); i++)
        if (dec_bits[i] != sent_all[i]) mism++;
      chk(mism == 0, "R3 decoded bit order", mism, 0);
    end
    finish_run();
  end
endmodule